// File: doc/BRIEF.md
# Discoverable-Parameter Table Read Responder

This block sits behind the byte-level front end of an emulated serial flash device. It answers the command that reads the device's discoverable-parameter table. The table is 88 bytes long and is held in logic. A command arrives as a stream of write bytes: the opcode, three address bytes sent most significant first, an optional dummy byte, and any number of surplus bytes. The block then enters a read phase and supplies one table byte per accepted read beat, until the host ends the transaction.

The start offset is formed from the three address bytes modulo the table size. It is reduced one bit per cycle as each address byte arrives. Two things can move the start of the response. If the host omits the dummy byte, the first read beat is spent as the dummy. If the host sends more than five write bytes, each surplus byte advances the start offset by one, modulo the table size. Reads that run past the last table byte return 0xFF and set a sticky flag. The response is only given when the configuration input allows it.

Both byte streams use valid/ready. On the write side, `wr_ready` is low for the 8 cycles that follow each accepted address byte, and from the last write byte until the transaction ends. A held write byte stays pending until the block takes it. On the read side, `rd_valid` is high for the whole read phase. `rd_data` holds steady until a beat is accepted with `rd_ready`. The host may stall the read side for any number of cycles. `txn_end` is a single-cycle pulse that marks chip-select release. It aborts or finishes any transaction and returns the block to the command phase.

Top module: `sfdp_responder`

## Requirements
- R1: Out of reset and between transactions, `wr_ready` is high. After each accepted address byte (write bytes 1 to 3), `wr_ready` is low for exactly 8 cycles. From the byte flagged `wr_last` until `txn_end`, no further write byte is accepted.
- R2: A table response is given only when all three of these hold: `sfdp_en` is high when the write phase closes, the first write byte equals 0x5A, and at least 4 write bytes were sent. In every other case, every read beat returns 0xFF.
- R3: Table bytes 0x00..0x17 are as follows. 0x00..0x03: 53 46 44 50. 0x04..0x07: 00 01 01 FF. 0x08..0x0B: 00 00 01 09. 0x0C..0x0F: 1C 00 00 FF. 0x10..0x13: VENDOR_ID 00 01 04, where VENDOR_ID defaults to 0x5E. 0x14..0x17: 48 00 00 FF.
- R4: Write bytes 1, 2 and 3 form a 24-bit address, most significant byte first. The start offset is this address modulo 88.
- R5: With exactly 4 write bytes, the first read beat returns 0xFF. Table data starts at the second read beat.
- R6: With N > 5 write bytes, the start offset is (address + N - 5) modulo 88.
- R7: Bytes are streamed from the start offset to index 87. Every later beat returns 0xFF. Accepting the first such beat sets `bound_crossed`, which stays set until reset.
- R8: `rd_valid` is high throughout the read phase. `rd_data` does not change while a beat is offered but not accepted.
- R9: `txn_end` returns the block to the command phase from any point, including in the middle of a write phase. The next transaction is then decoded as if it were the first.
- R10: Indices 0x18..0x1B and 0x40..0x47 read 0xFF. Indices 0x1C..0x3F and 0x48..0x57 read (7*index + 3) modulo 256.
- R11: In reset, `wr_ready` is 1, `rd_valid` is 0 and `bound_crossed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfdp_en | input | 1 | Configuration: emulated device answers the table read |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted this cycle when high |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Marks the final write byte of the command |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| txn_end | input | 1 | Transaction end pulse (chip select released) |
| bound_crossed | output | 1 | Sticky: a read ran past the table end |

## Verification
A corrupted offset accumulator appears as a wrong first data byte on the very first accepted read beat. The byte is shifted by the error modulo 88, so each address, wrap and surplus-byte case shows up in the first compare. A mistaken dummy or enable latch shows up in the same beat, as a table byte where 0xFF is expected or the other way round. A wrong reduction length shows up as a stall count other than 8 after the first address byte. A flag that fails to set, or that clears, is visible on `bound_crossed` right after the boundary beat of the transaction in question.

// File: rtl/sfdp_pkg.sv
package sfdp_pkg;

  typedef enum logic [0:0] {
    ST_CMD  = 1'b0,
    ST_READ = 1'b1
  } sfdp_state_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // Contents of one table entry; the header is fixed, parameter bodies are a
  // computed placeholder pattern, gaps between regions read as erased.
  function automatic logic [7:0] sfdp_byte(input int idx, input logic [7:0] vid);
    logic [7:0] b;
    case (idx)
      0:  b = 8'h53;
      1:  b = 8'h46;
      2:  b = 8'h44;
      3:  b = 8'h50;
      4:  b = 8'h00;
      5:  b = 8'h01;
      6:  b = 8'h01;
      7:  b = 8'hFF;
      8:  b = 8'h00;
      9:  b = 8'h00;
      10: b = 8'h01;
      11: b = 8'h09;
      12: b = 8'h1C;
      13: b = 8'h00;
      14: b = 8'h00;
      15: b = 8'hFF;
      16: b = vid;
      17: b = 8'h00;
      18: b = 8'h01;
      19: b = 8'h04;
      20: b = 8'h48;
      21: b = 8'h00;
      22: b = 8'h00;
      23: b = 8'hFF;
      default: begin
        if ((idx >= 28 && idx < 64) || (idx >= 72 && idx < 88))
          b = 8'((idx * 7) + 3);
        else
          b = 8'hFF;
      end
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sfdp_table_rom.sv
module sfdp_table_rom #(
  parameter int         TBL_BYTES = 88,
  parameter logic [7:0] VENDOR_ID = 8'h5E,
  parameter int         IW        = 7
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    byte_o
);
  localparam logic [IW-1:0] LIMIT = IW'(TBL_BYTES);

  logic [7:0] entry [TBL_BYTES];

  for (genvar g = 0; g < TBL_BYTES; g++) begin : g_entry
    assign entry[g] = sfdp_pkg::sfdp_byte(g, VENDOR_ID);
  end

  always_comb begin
    byte_o = sfdp_pkg::FILL_BYTE;
    for (int i = 0; i < TBL_BYTES; i++) begin
      if (idx == IW'(i) && idx < LIMIT) byte_o = entry[i];
    end
  end
endmodule

// File: rtl/sfdp_offset_acc.sv
module sfdp_offset_acc #(
  parameter int TBL_BYTES = 88,
  parameter int OW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [7:0]    load_byte,
  input  logic          bump,
  input  logic          step,
  output logic [OW-1:0] offs,
  output logic          busy
);
  localparam logic [OW:0]   MOD_W  = (OW+1)'(TBL_BYTES);
  localparam logic [OW-1:0] LAST_I = OW'(TBL_BYTES - 1);

  logic [OW-1:0] r_q;
  logic [7:0]    sh_q;
  logic [3:0]    bits_q;
  logic [OW:0]   dbl;
  logic [OW:0]   red;

  assign busy = (bits_q != 4'd0);
  assign offs = r_q;
  assign dbl  = {r_q, sh_q[7]};
  assign red  = (dbl >= MOD_W) ? (dbl - MOD_W) : dbl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q    <= '0;
      sh_q   <= '0;
      bits_q <= '0;
    end else if (clr) begin
      r_q    <= '0;
      bits_q <= '0;
    end else if (busy) begin
      r_q    <= red[OW-1:0];
      sh_q   <= {sh_q[6:0], 1'b0};
      bits_q <= bits_q - 4'd1;
    end else if (load) begin
      sh_q   <= load_byte;
      bits_q <= 4'd8;
    end else if (bump) begin
      r_q <= (r_q == LAST_I) ? '0 : r_q + 1'b1;
    end else if (step) begin
      r_q <= r_q + 1'b1;
    end
  end

  a_r4_offs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    r_q <= OW'(TBL_BYTES));

  a_r1_reduce_length: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy && !clr) |=> (bits_q == 4'd8));
endmodule

// File: rtl/sfdp_responder.sv
module sfdp_responder #(
  parameter int         TBL_BYTES = 88,
  parameter logic [7:0] VENDOR_ID = 8'h5E,
  parameter logic [7:0] OPCODE    = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfdp_en,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  input  logic       txn_end,
  output logic       bound_crossed
);
  import sfdp_pkg::*;

  localparam int            OW    = $clog2(TBL_BYTES + 1);
  localparam logic [OW-1:0] LIMIT = OW'(TBL_BYTES);

  sfdp_state_t st_q;
  logic [2:0]  cnt_q;
  logic [7:0]  op_q;
  logic        pend_q, resp_q, dummy_q, flag_q;

  logic          wr_fire, rd_fire, busy, enter_rd;
  logic          acc_load, acc_bump, acc_step;
  logic [OW-1:0] offs;
  logic [7:0]    rom_byte;

  assign wr_ready = (st_q == ST_CMD) && !busy && !pend_q;
  assign rd_valid = (st_q == ST_READ);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign enter_rd = pend_q && !busy && !txn_end;

  assign acc_load = wr_fire && (cnt_q >= 3'd1) && (cnt_q <= 3'd3);
  assign acc_bump = wr_fire && (cnt_q >= 3'd5);
  assign acc_step = rd_fire && resp_q && !dummy_q && (offs < LIMIT);

  sfdp_offset_acc #(.TBL_BYTES(TBL_BYTES), .OW(OW)) i_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (txn_end),
    .load      (acc_load),
    .load_byte (wr_data),
    .bump      (acc_bump),
    .step      (acc_step),
    .offs      (offs),
    .busy      (busy)
  );

  sfdp_table_rom #(.TBL_BYTES(TBL_BYTES), .VENDOR_ID(VENDOR_ID), .IW(OW)) i_rom (
    .idx    (offs),
    .byte_o (rom_byte)
  );

  assign rd_data       = (!resp_q || dummy_q) ? FILL_BYTE : rom_byte;
  assign bound_crossed = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_CMD;
      cnt_q   <= '0;
      op_q    <= '0;
      pend_q  <= 1'b0;
      resp_q  <= 1'b0;
      dummy_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (txn_end) begin
      st_q    <= ST_CMD;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      resp_q  <= 1'b0;
      dummy_q <= 1'b0;
    end else begin
      case (st_q)
        ST_CMD: begin
          if (wr_fire) begin
            if (cnt_q == 3'd0) op_q <= wr_data;
            if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
            if (wr_last) pend_q <= 1'b1;
          end
          if (enter_rd) begin
            st_q    <= ST_READ;
            pend_q  <= 1'b0;
            resp_q  <= sfdp_en && (op_q == OPCODE) && (cnt_q >= 3'd4);
            dummy_q <= (cnt_q == 3'd4);
          end
        end
        ST_READ: begin
          if (rd_fire && resp_q && dummy_q) dummy_q <= 1'b0;
          if (rd_fire && resp_q && !dummy_q && (offs >= LIMIT)) flag_q <= 1'b1;
        end
        default: st_q <= ST_CMD;
      endcase
    end
  end

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);

  a_r7_past_end_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && resp_q && !dummy_q && offs >= LIMIT) |-> (rd_data == 8'hFF));

  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !txn_end) |=> (rd_valid && $stable(rd_data)));

  a_r5_dummy_spent_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dummy_q) && !$past(txn_end)) |-> $past(rd_valid && rd_ready));

  a_r6_surplus_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bump && !txn_end) |=>
      (offs == (($past(offs) == LIMIT - 1'b1) ? '0 : $past(offs) + 1'b1)));
endmodule

// File: tb/test_sfdp_responder.sv
module test_sfdp_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfdp_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       wr_last = 1'b0;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       txn_end = 1'b0;
  logic       bound_crossed;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  int last_stall = 0;
  bit exp_flag = 1'b0;

  always #4 clk = ~clk;

  sfdp_responder i_sfdp_responder (
    .clk(clk), .rst_n(rst_n), .sfdp_en(sfdp_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .txn_end(txn_end), .bound_crossed(bound_crossed)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // Table contents from R3 and R10
  function automatic logic [7:0] ref_tbl(input int i);
    logic [7:0] hdr [24] = '{8'h53, 8'h46, 8'h44, 8'h50, 8'h00, 8'h01, 8'h01, 8'hFF,
                             8'h00, 8'h00, 8'h01, 8'h09, 8'h1C, 8'h00, 8'h00, 8'hFF,
                             8'h5E, 8'h00, 8'h01, 8'h04, 8'h48, 8'h00, 8'h00, 8'hFF};
    if (i < 24) return hdr[i];
    if ((i >= 28 && i < 64) || (i >= 72 && i < 88)) return 8'((i * 7) + 3);
    return 8'hFF;
  endfunction

  // Expected byte on read beat k (R2, R4, R5, R6, R7); sets past_end
  function automatic logic [7:0] ref_rd(input logic [7:0] op, input int addr, input int nwr,
                                        input logic en, input int k, output bit past_end);
    int j, off, idx;
    past_end = 1'b0;
    if (!(en && op == 8'h5A && nwr >= 4)) return 8'hFF;
    j = k;
    if (nwr == 4) begin
      if (j == 0) return 8'hFF;
      j--;
    end
    off = ((addr & 24'hFFFFFF) + ((nwr > 5) ? nwr - 5 : 0)) % 88;
    idx = off + j;
    if (idx >= 88) begin
      past_end = 1'b1;
      return 8'hFF;
    end
    return ref_tbl(idx);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic end_txn();
    @(negedge clk) txn_end = 1'b1;
    @(negedge clk) txn_end = 1'b0;
  endtask

  task automatic run_txn(input string tag, input logic [7:0] op, input int addr, input int nwr,
                         input logic en, input int nrd, input bit stall);
    logic [7:0] b;
    logic [7:0] held;
    bit pe;
    sfdp_en = en;
    @(negedge clk);
    for (int i = 0; i < nwr; i++) begin
      b = (i == 0) ? op : (i == 1) ? 8'(addr >> 16) : (i == 2) ? 8'(addr >> 8) :
          (i == 3) ? 8'(addr) : 8'(8'hC0 + i);
      wr_valid = 1'b1; wr_data = b; wr_last = (i == nwr - 1);
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      if (i == 1) begin
        last_stall = 0;
        while (!wr_ready && !wr_last) begin
          last_stall++;
          @(negedge clk);
        end
      end
    end
    wr_valid = 1'b0; wr_last = 1'b0;
    for (int k = 0; k < nrd; k++) begin
      while (!rd_valid) @(negedge clk);
      b = ref_rd(op, addr, nwr, en, k, pe);
      if (stall && (k % 3 == 1)) begin
        held = rd_data;
        @(negedge clk);
        check("R8 held byte", rd_data, held);
      end
      check(tag, rd_data, b);
      if (pe) exp_flag = 1'b1;
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    check("R7 flag", bound_crossed, exp_flag);
    check("R1 no write in read", wr_ready, (nwr > 0) ? 0 : 1);
    end_txn();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 wr_ready", wr_ready, 1);
    check("R11 rd_valid", rd_valid, 0);
    check("R11 flag", bound_crossed, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 header from offset 0, with read stalls (R8)
    run_txn("R3 header", 8'h5A, 0, 5, 1'b1, 24, 1'b1);
    check("R1 stall after address byte", last_stall, 8);
    // R10 body and gaps
    run_txn("R10 body", 8'h5A, 24, 5, 1'b1, 48, 1'b0);
    run_txn("R10 second body", 8'h5A, 70, 5, 1'b1, 12, 1'b0);
    // R5 dummy omitted
    run_txn("R5 dummy omitted", 8'h5A, 16, 4, 1'b1, 6, 1'b0);
    // R6 surplus bytes
    run_txn("R6 surplus", 8'h5A, 2, 8, 1'b1, 6, 1'b0);
    run_txn("R6 surplus wrap", 8'h5A, 87, 6, 1'b1, 4, 1'b0);
    // R4 address wrap and byte order
    run_txn("R4 wrap small", 8'h5A, 91, 5, 1'b1, 4, 1'b0);
    run_txn("R4 wrap large", 8'h5A, 24'hABCDEF, 5, 1'b1, 5, 1'b0);
    run_txn("R4 byte order", 8'h5A, 24'h000113, 5, 1'b1, 4, 1'b0);
    // R2 no response cases
    run_txn("R2 disabled", 8'h5A, 0, 5, 1'b0, 4, 1'b0);
    run_txn("R2 other opcode", 8'h9F, 0, 5, 1'b1, 4, 1'b0);
    run_txn("R2 short command", 8'h5A, 0, 3, 1'b1, 3, 1'b0);
    check("R7 flag still low", bound_crossed, 0);
    // R7 boundary crossing, then stickiness
    run_txn("R7 boundary", 8'h5A, 84, 5, 1'b1, 7, 1'b0);
    run_txn("R7 after crossing", 8'h5A, 0, 5, 1'b1, 4, 1'b0);
    // R9 abort mid-command, then a clean transaction
    @(negedge clk) wr_valid = 1'b1; wr_data = 8'h5A; wr_last = 1'b0;
    @(negedge clk) wr_data = 8'h00;
    while (!wr_ready) @(negedge clk);
    @(negedge clk) wr_valid = 1'b0;
    end_txn();
    check("R9 ready after abort", wr_ready, 1);
    run_txn("R9 after abort", 8'h5A, 12, 5, 1'b1, 4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule